// File: doc/BRIEF.md
# Tick Counter with Compare Interrupt

This block keeps a free-running tick counter that advances once for every cycle in which the timer-rate enable is high. Nominally that enable arrives at 100 MHz. Software can load the counter directly, and it can program a limit value. When the counter reaches an armed limit, the block emits a one-cycle match pulse. It also sets a sticky soft-interrupt bit, which the interrupt resolver samples and software later clears.

One bit position, `CTRL_BIT` (default 63), is never part of the stored values. Any write to the count or the limit moves that bit of the written word into a single shared disable flag. Both read views show the flag in that bit position. While the flag is set, no match is produced.

A limit whose remaining bits are all zero never arms the compare, and writing one cancels any compare still pending. Each compare is one-shot: after a match the limit must be written again before another match can occur. Reset clears the counter and the limit, cancels any pending compare and sets the disable flag.

Top module: `tick_cmp_top`

## Requirements
- R1: After reset the counter and limit are zero, the disable flag is set (both reads return 0x8000_0000_0000_0000), no compare is armed, and `match_pulse` and `sint_out` are low.
- R2: The counter increases by one on each clock edge where `tick_en` is high and no count write happens, and it holds its value otherwise.
- R3: A count write (`wr_en`=1, `wr_sel`=0) loads `wr_data` with bit `CTRL_BIT` cleared into the counter and copies `wr_data[CTRL_BIT]` into the disable flag. It takes precedence over `tick_en` in the same cycle.
- R4: With `rd_sel`=0, `rd_data` is the counter value; with `rd_sel`=1 it is the stored limit. In both cases bit `CTRL_BIT` equals the disable flag. The read is combinational.
- R5: A limit write (`wr_en`=1, `wr_sel`=1) stores `wr_data` with bit `CTRL_BIT` cleared and copies `wr_data[CTRL_BIT]` into the disable flag. It arms the compare only when the stored value is nonzero and the written control bit is 0.
- R6: A limit write whose stored value is zero leaves the compare unarmed and cancels a compare that was already armed.
- R7: While the disable flag is set, `match_pulse` does not rise and `sint_out` is not set by the compare.
- R8: When the compare is armed, the flag is clear and the counter equals the limit, `match_pulse` is high for exactly one cycle, one clock later. In the same cycle `sint_out` is set and the compare disarms, so a later pass of the counter produces no second match.
- R9: `sint_out` stays high until `sint_clr` is high at a clock edge. A match on the same edge as a clear leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer-rate count enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 count, 1 limit |
| wr_data | input | 64 | Write value including control bit |
| rd_sel | input | 1 | Read source: 0 count, 1 limit |
| rd_data | output | 64 | Selected register with control bit showing the disable flag |
| sint_clr | input | 1 | Clears the soft-interrupt bit |
| match_pulse | output | 1 | One-cycle compare match pulse |
| sint_out | output | 1 | Sticky soft-interrupt match bit |

## Verification
A vector table of count and limit writes, with and without the control bit, shows that masking and the shared flag behave the same way for both registers. It also separates the stored value from the flag view. Counting runs with the enable toggled show the increment rule and the precedence of a load over a tick. Runs that carry the counter across the limit are repeated in four settings: armed and enabled, armed but disabled, cancelled by a zero limit, and after a reset mid-run. Only the first setting may produce a match. A limit equal to the current count, written while a clear is pending, tells whether a match or a clear takes priority.

// File: rtl/tick_cmp_pkg.sv
package tick_cmp_pkg;
    // register select encoding on the write and read ports
    typedef enum logic {
        SEL_COUNT = 1'b0,
        SEL_LIMIT = 1'b1
    } tick_sel_e;

    // remove the control bit from a register word
    function automatic logic [63:0] strip_ctrl(input logic [63:0] val,
                                               input logic [63:0] mask);
        return val & ~mask;
    endfunction
endpackage

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int W        = 64,
    parameter int CTRL_BIT = 63
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt_q
);
    localparam logic [W-1:0] CTRL_MASK = W'(1) << CTRL_BIT;

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = load_val & ~CTRL_MASK;
        end else if (tick_en) begin
            st_d.cnt = (st_q.cnt + W'(1)) & ~CTRL_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q = st_q.cnt;

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !load) |=> $stable(cnt_q)); // R2

    AST_CNT_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (load && tick_en) |=> (cnt_q == ($past(load_val) & ~CTRL_MASK))); // R3
endmodule

// File: rtl/tick_flag.sv
module tick_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_any,
    input  logic wr_bit,
    output logic dis_q
);
    typedef struct packed {
        logic dis;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_any) begin
            st_d.dis = wr_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{dis: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign dis_q = st_q.dis;

    AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_any |=> $stable(dis_q)); // R3
endmodule

// File: rtl/tick_compare.sv
module tick_compare #(
    parameter int W        = 64,
    parameter int CTRL_BIT = 63
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lim_wr,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] cnt,
    input  logic         dis,
    output logic [W-1:0] lim_q,
    output logic         hit
);
    localparam logic [W-1:0] CTRL_MASK = W'(1) << CTRL_BIT;

    typedef struct packed {
        logic [W-1:0] lim;
        logic         armed;
    } cmp_st_t;

    cmp_st_t      st_d, st_q;
    logic [W-1:0] new_lim;

    assign new_lim = wr_data & ~CTRL_MASK;
    // a write in progress suppresses the compare so it sees settled state
    assign hit     = st_q.armed && !dis && !lim_wr && (cnt == st_q.lim);

    always_comb begin
        st_d = st_q;
        if (lim_wr) begin
            st_d.lim   = new_lim;
            st_d.armed = (new_lim != '0) && !wr_data[CTRL_BIT];
        end else if (hit) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lim_q = st_q.lim;

    AST_ZERO_LIMIT_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_wr && (new_lim == '0)) |=> !hit); // R6

    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit); // R8
endmodule

// File: rtl/tick_softint.sv
module tick_softint (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    output logic pulse_q,
    output logic sint_q
);
    typedef struct packed {
        logic pulse;
        logic sint;
    } si_st_t;

    si_st_t st_d, st_q;

    always_comb begin
        st_d.pulse = hit;
        st_d.sint  = hit | (st_q.sint & ~clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_q = st_q.pulse;
    assign sint_q  = st_q.sint;

    AST_SINT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sint_q && !clr) |=> sint_q); // R9

    AST_PULSE_SETS_SINT: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> sint_q); // R8
endmodule

// File: rtl/tick_cmp_top.sv
module tick_cmp_top #(
    parameter int W        = 64,
    parameter int CTRL_BIT = 63
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         rd_sel,
    output logic [W-1:0] rd_data,
    input  logic         sint_clr,
    output logic         match_pulse,
    output logic         sint_out
);
    import tick_cmp_pkg::*;

    localparam logic [W-1:0] CTRL_MASK = W'(1) << CTRL_BIT;

    logic         wr_cnt, wr_lim;
    logic [W-1:0] cnt_q, lim_q;
    logic         dis_q, hit;

    assign wr_cnt = wr_en && (tick_sel_e'(wr_sel) == SEL_COUNT);
    assign wr_lim = wr_en && (tick_sel_e'(wr_sel) == SEL_LIMIT);

    tick_counter #(.W(W), .CTRL_BIT(CTRL_BIT)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .load     (wr_cnt),
        .load_val (wr_data),
        .cnt_q    (cnt_q)
    );

    tick_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_any (wr_en),
        .wr_bit (wr_data[CTRL_BIT]),
        .dis_q  (dis_q)
    );

    tick_compare #(.W(W), .CTRL_BIT(CTRL_BIT)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .lim_wr  (wr_lim),
        .wr_data (wr_data),
        .cnt     (cnt_q),
        .dis     (dis_q),
        .lim_q   (lim_q),
        .hit     (hit)
    );

    tick_softint u_si (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .clr     (sint_clr),
        .pulse_q (match_pulse),
        .sint_q  (sint_out)
    );

    always_comb begin
        if (tick_sel_e'(rd_sel) == SEL_LIMIT) begin
            rd_data = lim_q;
        end else begin
            rd_data = cnt_q;
        end
        if (dis_q) begin
            rd_data = rd_data | CTRL_MASK;
        end
    end

    AST_NO_MATCH_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        dis_q |=> !match_pulse); // R7

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |=> !match_pulse); // R8
endmodule

// File: tb/tb_tick_cmp_top.sv
module tb_tick_cmp_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [63:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [63:0] rd_data;
    logic        sint_clr = 1'b0;
    logic        match_pulse;
    logic        sint_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tick_cmp_top dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .sint_clr(sint_clr), .match_pulse(match_pulse), .sint_out(sint_out)
    );

    localparam logic [63:0] TOPB = 64'h8000_0000_0000_0000;

    // {select, written word, expected read of the same register}
    localparam logic [128:0] VEC [6] = '{
        {1'b0, 64'h0000_0000_0000_0010, 64'h0000_0000_0000_0010},
        {1'b0, 64'h8000_0000_0000_0020, 64'h8000_0000_0000_0020},
        {1'b1, 64'h8000_0000_0000_0055, 64'h8000_0000_0000_0055},
        {1'b1, 64'h0000_0000_0000_0100, 64'h0000_0000_0000_0100},
        {1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
        {1'b1, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic sel, input logic [63:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [63:0] val);
        rd_sel = sel;
        #1 val = rd_data;
    endtask

    task automatic run_ticks(input int n, output int pulses);
        pulses = 0;
        @(negedge clk);
        tick_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (match_pulse) pulses++;
        end
        tick_en = 1'b0;
    endtask

    initial begin
        logic [63:0] v;
        int p;
        int p_at;
        logic [63:0] c_at;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(1'b0, v); chk("R1 count after reset", v, TOPB);
        rd(1'b1, v); chk("R1 limit after reset", v, TOPB);
        chk("R1 sint after reset", {63'd0, sint_out}, 64'd0);
        chk("R1 pulse after reset", {63'd0, match_pulse}, 64'd0);

        // R3 R4 R5 table walk
        foreach (VEC[k]) begin
            do_write(VEC[k][128], VEC[k][127:64]);
            rd(VEC[k][128], v);
            chk(VEC[k][128] ? "R5 limit write/read" : "R3 R4 count write/read", v, VEC[k][63:0]);
        end
        chk("R5 no match during table", {63'd0, sint_out}, 64'd0);

        // R2 counting
        do_write(1'b0, 64'd0);
        run_ticks(5, p);
        rd(1'b0, v); chk("R2 five ticks", v, 64'd5);
        repeat (3) @(negedge clk);
        rd(1'b0, v); chk("R2 hold without tick", v, 64'd5);

        // R3 load over tick
        @(negedge clk);
        tick_en = 1'b1; wr_en = 1'b1; wr_sel = 1'b0; wr_data = 64'h40;
        @(negedge clk);
        tick_en = 1'b0; wr_en = 1'b0;
        rd(1'b0, v); chk("R3 load wins over tick", v, 64'h40);

        // R8 match
        do_write(1'b0, 64'h10);
        do_write(1'b1, 64'h14);
        rd_sel = 1'b0;
        p_at = 0; c_at = '0;
        @(negedge clk);
        tick_en = 1'b1;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (match_pulse) begin
                p_at++;
                c_at = rd_data;
            end
        end
        tick_en = 1'b0;
        chk("R8 exactly one pulse", 64'(p_at), 64'd1);
        chk("R8 pulse one clock after equality", c_at, 64'h15);
        chk("R8 sint set", {63'd0, sint_out}, 64'd1);

        // R9 hold and clear
        repeat (4) @(negedge clk);
        chk("R9 sint held", {63'd0, sint_out}, 64'd1);
        sint_clr = 1'b1; @(negedge clk); sint_clr = 1'b0;
        chk("R9 sint cleared", {63'd0, sint_out}, 64'd0);

        // R9 set wins over clear
        do_write(1'b0, 64'h30);
        do_write(1'b1, 64'h30);
        sint_clr = 1'b1;
        @(negedge clk);
        sint_clr = 1'b0;
        chk("R8 pulse at equal limit", {63'd0, match_pulse}, 64'd1);
        chk("R9 set over clear", {63'd0, sint_out}, 64'd1);
        sint_clr = 1'b1; @(negedge clk); sint_clr = 1'b0;
        chk("R9 cleared again", {63'd0, sint_out}, 64'd0);

        // R7 disabled
        do_write(1'b1, 64'h70);
        do_write(1'b0, TOPB | 64'h68);
        run_ticks(12, p);
        chk("R7 no pulse while disabled", 64'(p), 64'd0);
        chk("R7 no sint while disabled", {63'd0, sint_out}, 64'd0);
        rd(1'b0, v); chk("R7 R4 count view", v, TOPB | 64'h74);

        // R6 zero limit cancels
        do_write(1'b0, 64'h80);
        do_write(1'b1, 64'h90);
        do_write(1'b1, 64'h0);
        run_ticks(24, p);
        chk("R6 no pulse after zero limit", 64'(p), 64'd0);
        rd(1'b0, v); chk("R6 count ran past", v, 64'h98);
        do_write(1'b0, 64'h0);
        repeat (3) @(negedge clk);
        chk("R6 zero count vs zero limit", {63'd0, sint_out}, 64'd0);

        // R1 reset mid-run
        do_write(1'b0, 64'h5);
        do_write(1'b1, 64'h8);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        run_ticks(12, p);
        chk("R1 reset cancels compare", 64'(p), 64'd0);
        rd(1'b0, v); chk("R1 count restarts from zero", v, TOPB | 64'hC);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule